// File: doc/BRIEF.md
# Up-Counting Compare Timer

This block is a 16-bit timer that counts up from zero. Each pulse on its tick input advances it by one. A write to its control word starts it. At that moment it copies compare register A into a private period register. From then on, each time the count reaches that period, it raises a one-clock period event and returns to zero. A second compare register, B, and the live value of register A each raise their own one-clock match pulse when a tick brings the count to their value.

Software reaches the block through a small register port that takes byte and halfword accesses. The port holds:

- a two-byte control word; the second byte carries the run-enable and load bits;
- two compare registers;
- two 8-bit channel mode registers;
- a read-only view of the count.

Any access the port does not accept is dropped without changing state. It raises an error pulse in the next cycle. Such accesses are a wrong size, an unmapped address, a write to the count, or a control value that is illegal. A stopped timer holds its count at zero, so reading the count while it is stopped returns zero.

Top module: `upcount_cmp_timer`

## Requirements
- R1: After reset the timer is stopped and every register reads 0x00/0x0000. While the timer is stopped the count (address 0x8) reads zero and ticks leave it at zero.
- R2: While running, each cycle with `tick` high adds one to the count, which starts from zero when the timer is started.
- R3: The period is the value of compare A (address 0x4) at start. When a tick brings the count to the period, `period_evt` pulses for one clock and the count becomes zero. Writing compare A while running does not change the current period.
- R4: If compare A is zero at start, no period event occurs and the count keeps rising past any value.
- R5: `cmp_a_hit` and `cmp_b_hit` each pulse for one clock after a tick that brings the count to the current nonzero value of compare A or compare B (address 0x6).
- R6: A legal write of control byte 1 (address 0x1) with run-enable bit 7 set restarts the count from zero, even mid-run. A write with bit 7 clear stops the timer.
- R7: Control byte 0 (address 0x0) and byte 1 can each be written by a byte access. A halfword access at 0x0 covers both, with byte 0 in bits 15:8 and byte 1 in bits 7:0.
- R8: A control write is rejected whole, with `acc_err` pulsing in the next cycle, if byte 1 has bits 7 and 6 both set, if byte 1 has any of bits 2:0 set, or if byte 0 has any of bits 5, 3 or 2 set.
- R9: The compare registers take byte and halfword accesses, and a byte write zero-extends. The channel mode registers (0x2, 0x3) take byte accesses only. A halfword access to them, or to 0x1, is rejected with `acc_err`.
- R10: An access with `acc_size` of 2 or 3 (wider than a halfword), any access to an unmapped address, and any write to the count are rejected with `acc_err` and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count-advance strobe |
| acc_wr | input | 1 | Register write request |
| acc_rd | input | 1 | Register read request |
| acc_addr | input | 4 | Register address |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 and 3 illegal |
| acc_wdata | input | 16 | Write data, byte accesses use bits 7:0 |
| acc_rdata | output | 16 | Read data, same cycle as `acc_rd` |
| acc_err | output | 1 | One-clock pulse after a rejected access |
| period_evt | output | 1 | One-clock pulse when the count wraps at the period |
| cmp_a_hit | output | 1 | One-clock pulse on a compare A match |
| cmp_b_hit | output | 1 | One-clock pulse on a compare B match |

## Verification
The counting path is tried with four periods: a nonzero period of five, a period of two, a period changed by a compare write in mid-run, and a period of zero. These show whether the period was latched at start or read live, and whether a zero value is treated as "no period". Compare B is placed inside the period so that its match pulse can be told apart from the period event. The register port is tried with byte and halfword forms of each register, and with every class of rejected write. Each rejected write is followed by a readback, which shows that no state moved.

// File: rtl/uct_pkg.sv
// Package: shared constants for the up-counting compare timer.
// Assumes a 16-bit register port with byte and halfword accesses.
package uct_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTL0  = 4'h0;
    localparam logic [ADDR_W-1:0] A_CTL1  = 4'h1;
    localparam logic [ADDR_W-1:0] A_CMODA = 4'h2;
    localparam logic [ADDR_W-1:0] A_CMODB = 4'h3;
    localparam logic [ADDR_W-1:0] A_CMPA  = 4'h4;
    localparam logic [ADDR_W-1:0] A_CMPB  = 4'h6;
    localparam logic [ADDR_W-1:0] A_COUNT = 4'h8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_BAD2 = 2'b10,
        SZ_BAD3 = 2'b11
    } acc_size_e;

    localparam logic [7:0] CTL0_RSVD = 8'h2C;
    localparam logic [7:0] CTL1_RSVD = 8'h07;
    localparam int RUN_BIT  = 7;
    localparam int LOAD_BIT = 6;
endpackage

// File: rtl/uct_regfile.sv
// Module: register port of the timer. Decodes byte/halfword accesses, holds
// the control, channel-mode and compare registers, rejects illegal accesses
// whole, and turns legal control-byte-1 writes into start/stop requests.
// Assumes reads are combinational and that the error pulse follows one cycle later.
module uct_regfile
    import uct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] cnt_val,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_err,
    output logic [DATA_W-1:0] cmp_a,
    output logic [DATA_W-1:0] cmp_b,
    output logic              start_req,
    output logic              stop_req
);
    logic [7:0] ctl0_q, ctl1_q, cmoda_q, cmodb_q;
    logic       err_q;
    logic       is_byte, is_half, addr_ok, val_ok, wr_ok, rd_ok;
    logic       hit0, hit1;
    logic [7:0] new0, new1;

    // Purpose: classify the current access by address and size.
    always_comb begin
        is_byte = (acc_size == SZ_BYTE);
        is_half = (acc_size == SZ_HALF);
        unique case (acc_addr)
            A_CTL0, A_CMPA, A_CMPB:     addr_ok = is_byte || is_half;
            A_CTL1, A_CMODA, A_CMODB:   addr_ok = is_byte;
            A_COUNT:                    addr_ok = !acc_wr && (is_byte || is_half);
            default:                    addr_ok = 1'b0;
        endcase
    end

    // Purpose: validate the control bytes a write would update.
    always_comb begin
        hit0   = (acc_addr == A_CTL0);
        hit1   = (acc_addr == A_CTL1 && is_byte) || (acc_addr == A_CTL0 && is_half);
        new0   = is_half ? acc_wdata[15:8] : acc_wdata[7:0];
        new1   = acc_wdata[7:0];
        val_ok = !(hit0 && |(new0 & CTL0_RSVD))
              && !(hit1 && (|(new1 & CTL1_RSVD) || (new1[RUN_BIT] && new1[LOAD_BIT])));
        wr_ok  = acc_wr && addr_ok && val_ok;
        rd_ok  = acc_rd && addr_ok;
    end

    assign start_req = wr_ok && hit1 && new1[RUN_BIT];
    assign stop_req  = wr_ok && hit1 && !new1[RUN_BIT];

    // Purpose: update registers on legal writes and register the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl0_q  <= '0;
            ctl1_q  <= '0;
            cmoda_q <= '0;
            cmodb_q <= '0;
            cmp_a   <= '0;
            cmp_b   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= (acc_wr && !(addr_ok && val_ok)) || (acc_rd && !addr_ok);
            if (wr_ok) begin
                if (hit0) ctl0_q <= new0;
                if (hit1) ctl1_q <= new1;
                if (acc_addr == A_CMODA) cmoda_q <= acc_wdata[7:0];
                if (acc_addr == A_CMODB) cmodb_q <= acc_wdata[7:0];
                if (acc_addr == A_CMPA) cmp_a <= is_half ? acc_wdata : {8'h00, acc_wdata[7:0]};
                if (acc_addr == A_CMPB) cmp_b <= is_half ? acc_wdata : {8'h00, acc_wdata[7:0]};
            end
        end
    end

    assign acc_err = err_q;

    // Purpose: return the addressed register, zero for rejected reads.
    always_comb begin
        acc_rdata = '0;
        if (rd_ok) begin
            unique case (acc_addr)
                A_CTL0:  acc_rdata = is_half ? {ctl0_q, ctl1_q} : {8'h00, ctl0_q};
                A_CTL1:  acc_rdata = {8'h00, ctl1_q};
                A_CMODA: acc_rdata = {8'h00, cmoda_q};
                A_CMODB: acc_rdata = {8'h00, cmodb_q};
                A_CMPA:  acc_rdata = is_half ? cmp_a : {8'h00, cmp_a[7:0]};
                A_CMPB:  acc_rdata = is_half ? cmp_b : {8'h00, cmp_b[7:0]};
                A_COUNT: acc_rdata = is_half ? cnt_val : {8'h00, cnt_val[7:0]};
                default: acc_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/uct_counter.sv
// Module: up-counter with a period latched at start. A start or stop request
// wins over a tick in the same cycle. A zero period disables wrapping and events.
module uct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         start_req,
    input  logic         stop_req,
    input  logic [W-1:0] period_src,
    output logic [W-1:0] cnt,
    output logic [W-1:0] period_cur,
    output logic         running,
    output logic         period_evt,
    output logic [W-1:0] step_val,
    output logic         step_vld
);
    localparam logic [W-1:0] ONE = W'(1);

    assign step_val = cnt + ONE;
    assign step_vld = running && tick && !start_req && !stop_req;

    // Purpose: run state, count, period latch and wrap event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            period_cur <= '0;
            running    <= 1'b0;
            period_evt <= 1'b0;
        end else if (start_req) begin
            cnt        <= '0;
            period_cur <= period_src;
            running    <= 1'b1;
            period_evt <= 1'b0;
        end else if (stop_req) begin
            cnt        <= '0;
            running    <= 1'b0;
            period_evt <= 1'b0;
        end else if (step_vld) begin
            if (period_cur != '0 && step_val == period_cur) begin
                cnt        <= '0;
                period_evt <= 1'b1;
            end else begin
                cnt        <= step_val;
                period_evt <= 1'b0;
            end
        end else begin
            period_evt <= 1'b0;
        end
    end
endmodule

// File: rtl/uct_compare.sv
// Module: per-channel match detectors. A channel pulses for one clock after a
// counting step whose reached value equals its nonzero reference.
module uct_compare #(
    parameter int W      = 16,
    parameter int NUM_CH = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_vld,
    input  logic [W-1:0]             step_val,
    input  logic [NUM_CH-1:0][W-1:0] ref_val,
    output logic [NUM_CH-1:0]        hit
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // Purpose: register a one-clock match pulse for channel i.
        always_ff @(posedge clk) begin
            if (!rst_n) hit[i] <= 1'b0;
            else        hit[i] <= step_vld && (ref_val[i] != '0) && (step_val == ref_val[i]);
        end
    end
endmodule

// File: rtl/upcount_cmp_timer.sv
// Module: top of the up-counting compare timer. Joins the register port,
// the counter and the two compare channels (channel 0 = A, channel 1 = B).
module upcount_cmp_timer
    import uct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_err,
    output logic              period_evt,
    output logic              cmp_a_hit,
    output logic              cmp_b_hit
);
    localparam int NUM_CH = 2;

    logic [DATA_W-1:0] cmp_a_w, cmp_b_w, cnt_w, per_w, step_val_w;
    logic              start_w, stop_w, run_w, step_vld_w;
    logic [NUM_CH-1:0] hit_w;

    uct_regfile u_regs (
        .clk(clk), .rst_n(rst_n),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_wdata(acc_wdata), .cnt_val(cnt_w),
        .acc_rdata(acc_rdata), .acc_err(acc_err),
        .cmp_a(cmp_a_w), .cmp_b(cmp_b_w),
        .start_req(start_w), .stop_req(stop_w)
    );

    uct_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .start_req(start_w), .stop_req(stop_w), .period_src(cmp_a_w),
        .cnt(cnt_w), .period_cur(per_w), .running(run_w),
        .period_evt(period_evt), .step_val(step_val_w), .step_vld(step_vld_w)
    );

    uct_compare #(.W(DATA_W), .NUM_CH(NUM_CH)) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .step_vld(step_vld_w), .step_val(step_val_w),
        .ref_val({cmp_b_w, cmp_a_w}), .hit(hit_w)
    );

    assign cmp_a_hit = hit_w[0];
    assign cmp_b_hit = hit_w[1];
endmodule

// File: rtl/uct_checker.sv
// Module: assertion checker for upcount_cmp_timer, attached by bind below.
// Observes ports plus the counter's run state, count and latched period.
module uct_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        acc_wr,
    input logic        acc_rd,
    input logic [3:0]  acc_addr,
    input logic [1:0]  acc_size,
    input logic [15:0] acc_wdata,
    input logic        acc_err,
    input logic        period_evt,
    input logic        cmp_a_hit,
    input logic        cmp_b_hit,
    input logic        running,
    input logic [15:0] cnt,
    input logic [15:0] per
);
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> cnt == 16'd0);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !acc_wr && per == 16'd0) |=> cnt == 16'($past(cnt) + 16'd1));

    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        period_evt |-> cnt == 16'd0);

    p_no_evt_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (per == 16'd0) |-> !period_evt);

    p_hit_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_a_hit || cmp_b_hit) |-> $past(tick));

    p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr == 4'h1 && acc_size == 2'b00 && acc_wdata[7:0] == 8'h00) |=> !running);

    p_run_load_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr == 4'h1 && acc_size == 2'b00 && acc_wdata[7] && acc_wdata[6]) |=> acc_err);

    p_wide_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_wr || acc_rd) && acc_size[1]) |=> acc_err);
endmodule

bind upcount_cmp_timer uct_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_err(acc_err),
    .period_evt(period_evt), .cmp_a_hit(cmp_a_hit), .cmp_b_hit(cmp_b_hit),
    .running(run_w), .cnt(cnt_w), .per(per_w)
);

// File: tb/tb_upcount_cmp_timer.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_upcount_cmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        acc_wr = 1'b0;
    logic        acc_rd = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        acc_err;
    logic        period_evt, cmp_a_hit, cmp_b_hit;

    int checks = 0;
    int fails = 0;
    int n_evt = 0, n_ha = 0, n_hb = 0;
    logic last_err;
    logic done = 1'b0;

    upcount_cmp_timer dut (.*);

    always #4 clk = ~clk;

    // Purpose: count one-clock output pulses away from the active edge.
    always @(negedge clk) begin
        if (period_evt) n_evt++;
        if (cmp_a_hit)  n_ha++;
        if (cmp_b_hit)  n_hb++;
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = a; acc_size = s; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0;
        last_err = acc_err;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] s, output logic [15:0] d);
        @(negedge clk);
        acc_rd = 1'b1; acc_addr = a; acc_size = s;
        #1 d = acc_rdata;
        @(negedge clk);
        acc_rd = 1'b0;
        last_err = acc_err;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(4'h1, 2'b00, v); check("R1 ctl1 after reset", v, 16'h0000);
        rd(4'h4, 2'b01, v); check("R1 cmpA after reset", v, 16'h0000);
        ticks(3);
        rd(4'h8, 2'b01, v); check("R1 count stopped", v, 16'h0000);
        check("R1 no pulses", 16'(n_evt + n_ha + n_hb), 16'd0);
    endtask

    task automatic t_period;
        logic [15:0] v;
        int e0, a0, b0;
        wr(4'h4, 2'b01, 16'd5);
        wr(4'h6, 2'b01, 16'd3);
        wr(4'h1, 2'b00, 16'h0080);
        e0 = n_evt; a0 = n_ha; b0 = n_hb;
        ticks(3);
        rd(4'h8, 2'b01, v); check("R2 count after 3 ticks", v, 16'd3);
        check("R5 compare B pulse", 16'(n_hb - b0), 16'd1);
        ticks(2);
        rd(4'h8, 2'b01, v); check("R3 wrap to zero", v, 16'd0);
        check("R3 one period event", 16'(n_evt - e0), 16'd1);
        check("R5 compare A pulse", 16'(n_ha - a0), 16'd1);
        wr(4'h4, 2'b01, 16'd2);
        e0 = n_evt;
        ticks(4);
        check("R3 period kept after cmpA write", 16'(n_evt - e0), 16'd0);
        rd(4'h8, 2'b01, v); check("R3 count past new cmpA", v, 16'd4);
        ticks(1);
        check("R3 event at old period", 16'(n_evt - e0), 16'd1);
    endtask

    task automatic t_restart_stop;
        logic [15:0] v;
        int e0;
        ticks(1);
        wr(4'h1, 2'b00, 16'h0080);
        rd(4'h8, 2'b01, v); check("R6 restart clears count", v, 16'd0);
        e0 = n_evt;
        ticks(4);
        check("R6 new period of two", 16'(n_evt - e0), 16'd2);
        ticks(1);
        wr(4'h1, 2'b00, 16'h0000);
        rd(4'h8, 2'b00, v); check("R6 stop clears count", v, 16'd0);
        ticks(2);
        rd(4'h8, 2'b01, v); check("R1 stopped ignores ticks", v, 16'd0);
    endtask

    task automatic t_zero_period;
        logic [15:0] v;
        int e0;
        wr(4'h4, 2'b01, 16'd0);
        wr(4'h1, 2'b00, 16'h0080);
        e0 = n_evt;
        ticks(10);
        rd(4'h8, 2'b01, v); check("R4 free count", v, 16'd10);
        check("R4 no period events", 16'(n_evt - e0), 16'd0);
    endtask

    task automatic t_mode_word;
        logic [15:0] v;
        wr(4'h0, 2'b01, 16'h1180);
        check("R7 halfword write accepted", 16'(last_err), 16'd0);
        rd(4'h0, 2'b01, v); check("R7 halfword order", v, 16'h1180);
        rd(4'h0, 2'b00, v); check("R7 byte0 alone", v, 16'h0011);
        wr(4'h0, 2'b00, 16'h0050);
        rd(4'h0, 2'b01, v); check("R7 byte write keeps byte1", v, 16'h5080);
    endtask

    task automatic t_illegal_mode;
        logic [15:0] v;
        wr(4'h1, 2'b00, 16'h00C0);
        check("R8 run+load error", 16'(last_err), 16'd1);
        wr(4'h1, 2'b00, 16'h0081);
        check("R8 byte1 reserved error", 16'(last_err), 16'd1);
        wr(4'h0, 2'b00, 16'h0004);
        check("R8 byte0 reserved error", 16'(last_err), 16'd1);
        wr(4'h0, 2'b01, 16'h00C0);
        check("R8 halfword bad byte1 error", 16'(last_err), 16'd1);
        rd(4'h0, 2'b01, v); check("R8 control unchanged", v, 16'h5080);
    endtask

    task automatic t_compare_regs;
        logic [15:0] v;
        wr(4'h6, 2'b01, 16'h1234);
        wr(4'h6, 2'b00, 16'h00AB);
        rd(4'h6, 2'b01, v); check("R9 byte write zero-extends", v, 16'h00AB);
        wr(4'h2, 2'b00, 16'h005A);
        rd(4'h2, 2'b00, v); check("R9 mode A byte", v, 16'h005A);
        wr(4'h3, 2'b01, 16'h7777);
        check("R9 halfword to mode B error", 16'(last_err), 16'd1);
        rd(4'h3, 2'b00, v); check("R9 mode B unchanged", v, 16'h0000);
        rd(4'h1, 2'b01, v); check("R9 halfword at 0x1 error", 16'(last_err), 16'd1);
    endtask

    task automatic t_bad_access;
        logic [15:0] v;
        rd(4'h4, 2'b10, v); check("R10 wide read error", 16'(last_err), 16'd1);
        wr(4'h6, 2'b11, 16'h4444);
        check("R10 wide write error", 16'(last_err), 16'd1);
        rd(4'h6, 2'b01, v); check("R10 cmpB unchanged", v, 16'h00AB);
        wr(4'h1, 2'b00, 16'h0000);
        wr(4'h8, 2'b01, 16'h0033);
        check("R10 count write error", 16'(last_err), 16'd1);
        rd(4'h8, 2'b01, v); check("R10 count unchanged", v, 16'h0000);
        rd(4'hE, 2'b00, v); check("R10 unmapped error", 16'(last_err), 16'd1);
    endtask

    // Purpose: end a hung run as a failure.
    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_period();
        t_restart_stop();
        t_zero_period();
        t_mode_word();
        t_illegal_mode();
        t_compare_regs();
        t_bad_access();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule